// File: doc/BRIEF.md
# Capture/Compare Timer with Status Flags

A 16-bit up-counter that advances once every four enabled clock cycles. It has two compare channels and two capture channels. The counter raises five event flags: one for each capture, one for each compare hit, and one for wrap-around. Software reads these flags through a status byte. The same byte holds a writable freeze bit.

A flag is cleared by a two-step handshake:
1. Software reads the status byte while the flag is set. This arms the flag.
2. Software then reads or writes the low byte of the data register that belongs to that flag.

A flag that was not yet visible when the status byte was read stays set, so no late event is lost. The counter can also be read through a second low-byte address. Accessing that address leaves the wrap flag untouched, so software can poll the count without losing a pending wrap.

All registers sit on a byte-wide synchronous bus. Read data is combinational from the address and the strobes, and writes take effect at the clock edge.

Top module: `cc_timer_flags`

Bus addresses (hex):
- 0: status
- 1: mode (bit 0 selects PWM mode)
- 2 / 3: counter high / low
- 4 / 5: counter high / low through the second address
- 6 / 7: capture A high / low
- 8 / 9: capture B high / low
- A / B: compare A high / low
- C / D: compare B high / low
- E and F read as zero.

## Requirements
- R1: The status byte holds, from bit 7 down: capture-A flag, compare-A flag, wrap flag, capture-B flag, compare-B flag, freeze bit (bit 2), and bits 1:0 which always read 0. After reset the status byte reads 00h.
- R2: A status write changes only the freeze bit, which reads back as written. The five flag bits are not writable.
- R3: While not frozen, the counter steps by one every 4 clock cycles. Any write to the counter low byte (address 3) reloads the counter with FFFCh and restarts the divider.
- R4: The wrap flag (status bit 5) sets on the edge where the counter steps from FFFFh to 0000h.
- R5: A compare flag sets on the edge where the counter steps onto the value held in its compare register.
- R6: A rising edge on a capture pin is seen after a two-flop synchronizer. It copies the counter into that channel's capture register and sets the channel's flag. Both results are visible after the third rising clock edge following the pin change.
- R7: With PWM mode set, the capture-A flag also sets on the edge where the counter steps onto compare B.
- R8: A flag clears only when both of these hold: the status byte was read while that flag was 1, and a later access hits the flag's own low byte (7, B, 3, 9 or D). A low-byte access without that prior read leaves the flag set.
- R9: Reading or writing the second counter low address (5) never clears the wrap flag.
- R10: A flag that sets after the arming status read, or in the same cycle as the clearing access, remains set.
- R11: While the freeze bit is 1, the divider and the counter hold, both compare outputs are 0, and register access, including the counter reload, still works.
- R12: Each compare output toggles on every hit of its own channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 4 | Register address |
| bus_rd | input | 1 | Read strobe (a read counts as an access) |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational |
| cap_a_pin | input | 1 | Capture input A (asynchronous) |
| cap_b_pin | input | 1 | Capture input B (asynchronous) |
| cmp_a_out | output | 1 | Compare output A |
| cmp_b_out | output | 1 | Compare output B |

## Verification
Register writes, counter steps, flag sets, flag clears and output toggles all land on the rising edge that samples the stimulus. The result therefore shows from the following cycle, and read data is valid in the same cycle as the address. Captures are the exception: they take three rising edges from the pin change.

The bench drives inputs at the falling edge and compares the read data and both outputs a moment later, still in the low phase. A bench reference model advances its own state only after each rising edge, so every comparison targets the cycle in which the result is due.

// File: rtl/cc_timer_flags.sv
module cc_timer_flags #(
  parameter int          PRE_DIV  = 4,
  parameter logic [15:0] RST_LOAD = 16'hFFFC
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] bus_addr,
  input  logic       bus_rd,
  input  logic       bus_wr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  input  logic       cap_a_pin,
  input  logic       cap_b_pin,
  output logic       cmp_a_out,
  output logic       cmp_b_out
);
  localparam int PW = (PRE_DIV > 1) ? $clog2(PRE_DIV) : 1;
  localparam logic [PW-1:0] PRE_TOP = PW'(PRE_DIV - 1);
  localparam logic [3:0] A_STAT = 4'h0, A_MODE = 4'h1, A_CNTH = 4'h2, A_CNTL = 4'h3,
                         A_ALTH = 4'h4, A_ALTL = 4'h5, A_CAH  = 4'h6, A_CAL  = 4'h7,
                         A_CBH  = 4'h8, A_CBL  = 4'h9, A_OAH  = 4'hA, A_OAL  = 4'hB,
                         A_OBH  = 4'hC, A_OBL  = 4'hD;

  // flag vector order matches status bits 7..3: capA, cmpA, wrap, capB, cmpB
  logic [PW-1:0] pre;
  logic [15:0]   cnt, cap_a, cap_b, cmp_a, cmp_b;
  logic          frz, pwm, tog_a, tog_b;
  logic [4:0]    flg, arm;
  logic [1:0]    sy1, sy2, sy3;

  wire        acc    = bus_rd | bus_wr;
  wire        stat_rd = bus_rd && bus_addr == A_STAT;
  wire        cnt_wr = bus_wr && bus_addr == A_CNTL;
  wire        tick   = !frz && pre == PRE_TOP;
  wire [15:0] nxt    = cnt + 16'd1;
  wire        hit_a  = tick && nxt == cmp_a;
  wire        hit_b  = tick && nxt == cmp_b;
  wire        wrap   = tick && cnt == 16'hFFFF;
  wire [1:0]  rise   = sy2 & ~sy3;
  wire [4:0]  set    = {rise[0] | (pwm & hit_b), hit_a, wrap, rise[1], hit_b};
  wire [4:0]  lo_acc = acc ? {bus_addr == A_CAL, bus_addr == A_OAL, bus_addr == A_CNTL,
                              bus_addr == A_CBL, bus_addr == A_OBL} : 5'd0;
  wire [4:0]  clr    = arm & lo_acc;

  assign cmp_a_out = tog_a & ~frz;
  assign cmp_b_out = tog_b & ~frz;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre <= '0; cnt <= 16'h0; cap_a <= 16'h0; cap_b <= 16'h0;
      cmp_a <= 16'hFFFF; cmp_b <= 16'hFFFF; frz <= 1'b0; pwm <= 1'b0;
      tog_a <= 1'b0; tog_b <= 1'b0; flg <= '0; arm <= '0;
      sy1 <= '0; sy2 <= '0; sy3 <= '0;
    end else begin
      sy1 <= {cap_b_pin, cap_a_pin};
      sy2 <= sy1;
      sy3 <= sy2;
      if (rise[0]) cap_a <= cnt;
      if (rise[1]) cap_b <= cnt;
      flg <= set | (flg & ~clr);
      arm <= stat_rd ? flg : (arm & ~lo_acc);
      tog_a <= tog_a ^ hit_a;
      tog_b <= tog_b ^ hit_b;
      if (cnt_wr) begin
        cnt <= RST_LOAD;
        pre <= '0;
      end else if (!frz) begin
        pre <= tick ? '0 : pre + 1'b1;
        if (tick) cnt <= nxt;
      end
      if (bus_wr) begin
        case (bus_addr)
          A_STAT: frz <= bus_wdata[2];
          A_MODE: pwm <= bus_wdata[0];
          A_OAH:  cmp_a[15:8] <= bus_wdata;
          A_OAL:  cmp_a[7:0]  <= bus_wdata;
          A_OBH:  cmp_b[15:8] <= bus_wdata;
          A_OBL:  cmp_b[7:0]  <= bus_wdata;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    bus_rdata = 8'h00;
    if (bus_rd) begin
      case (bus_addr)
        A_STAT:         bus_rdata = {flg, frz, 2'b00};
        A_MODE:         bus_rdata = {7'd0, pwm};
        A_CNTH, A_ALTH: bus_rdata = cnt[15:8];
        A_CNTL, A_ALTL: bus_rdata = cnt[7:0];
        A_CAH:          bus_rdata = cap_a[15:8];
        A_CAL:          bus_rdata = cap_a[7:0];
        A_CBH:          bus_rdata = cap_b[15:8];
        A_CBL:          bus_rdata = cap_b[7:0];
        A_OAH:          bus_rdata = cmp_a[15:8];
        A_OAL:          bus_rdata = cmp_a[7:0];
        A_OBH:          bus_rdata = cmp_b[15:8];
        A_OBL:          bus_rdata = cmp_b[7:0];
        default:        bus_rdata = 8'h00;
      endcase
    end
  end

  p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!frz && !cnt_wr) |=> (cnt == $past(cnt) || cnt == $past(cnt) + 16'd1));
  p_frozen_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (frz && !cnt_wr) |=> ($stable(cnt) && $stable(pre)));
  p_wrap_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && cnt == 16'hFFFF) |=> flg[2]);
  p_cmp_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && nxt == cmp_a) |=> (flg[3] && tog_a != $past(tog_a)));
  p_unarmed_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (flg[2] && !arm[2]) |=> flg[2]);
  p_alias_keep_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (flg[2] && acc && bus_addr == A_ALTL) |=> flg[2]);
endmodule

// File: tb/test_cc_timer_flags.sv
module test_cc_timer_flags;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [3:0] bus_addr = '0;
  logic bus_rd = 1'b0, bus_wr = 1'b0, cap_a_pin = 1'b0, cap_b_pin = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic cmp_a_out, cmp_b_out;
  int n_run = 0, n_fail = 0;

  always #5 clk = ~clk;

  cc_timer_flags i_cc_timer_flags (.*);

  // reference model state
  int         m_pre;
  logic [15:0] m_cnt, m_ca, m_cb, m_oa, m_ob;
  logic        m_frz, m_pwm, m_ta, m_tb;
  logic [4:0]  m_flg, m_arm;
  logic [1:0]  m_s1, m_s2, m_s3;

  task automatic m_reset();
    m_pre = 0; m_cnt = 0; m_ca = 0; m_cb = 0; m_oa = 16'hFFFF; m_ob = 16'hFFFF;
    m_frz = 0; m_pwm = 0; m_ta = 0; m_tb = 0; m_flg = 0; m_arm = 0;
    m_s1 = 0; m_s2 = 0; m_s3 = 0;
  endtask

  function automatic logic [7:0] m_read(input logic [3:0] a);
    case (a)
      4'h0: return {m_flg, m_frz, 2'b00};
      4'h1: return {7'd0, m_pwm};
      4'h2, 4'h4: return m_cnt[15:8];
      4'h3, 4'h5: return m_cnt[7:0];
      4'h6: return m_ca[15:8];
      4'h7: return m_ca[7:0];
      4'h8: return m_cb[15:8];
      4'h9: return m_cb[7:0];
      4'hA: return m_oa[15:8];
      4'hB: return m_oa[7:0];
      4'hC: return m_ob[15:8];
      4'hD: return m_ob[7:0];
      default: return 8'h00;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic cyc(input logic [3:0] a, input logic r, input logic w, input logic [7:0] d,
                     input logic [1:0] cp, input string tag);
    logic tk, ha, hb, wr;
    logic [15:0] nx;
    logic [1:0] rs;
    logic [4:0] st, la, cl;
    @(negedge clk);
    bus_addr = a; bus_rd = r; bus_wr = w; bus_wdata = d;
    cap_a_pin = cp[0]; cap_b_pin = cp[1];
    #1;
    if (r) chk(tag, {8'h00, bus_rdata}, {8'h00, m_read(a)});
    chk("R12 R11 outputs", {14'd0, cmp_b_out, cmp_a_out}, {14'd0, m_tb & ~m_frz, m_ta & ~m_frz});
    tk = !m_frz && m_pre == 3;
    nx = m_cnt + 16'd1;
    ha = tk && nx == m_oa; hb = tk && nx == m_ob; wr = tk && m_cnt == 16'hFFFF;
    rs = m_s2 & ~m_s3;
    st = {rs[0] | (m_pwm & hb), ha, wr, rs[1], hb};
    la = (r | w) ? {a == 4'h7, a == 4'hB, a == 4'h3, a == 4'h9, a == 4'hD} : 5'd0;
    cl = m_arm & la;
    @(posedge clk);
    if (rs[0]) m_ca = m_cnt;
    if (rs[1]) m_cb = m_cnt;
    m_arm = (r && a == 4'h0) ? m_flg : (m_arm & ~la);
    m_flg = st | (m_flg & ~cl);
    m_ta ^= ha; m_tb ^= hb;
    m_s3 = m_s2; m_s2 = m_s1; m_s1 = cp;
    if (w && a == 4'h3) begin m_cnt = 16'hFFFC; m_pre = 0; end
    else if (!m_frz) begin m_pre = tk ? 0 : m_pre + 1; if (tk) m_cnt = nx; end
    if (w) case (a)
      4'h0: m_frz = d[2];
      4'h1: m_pwm = d[0];
      4'hA: m_oa[15:8] = d;
      4'hB: m_oa[7:0] = d;
      4'hC: m_ob[15:8] = d;
      4'hD: m_ob[7:0] = d;
      default: ;
    endcase
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(4'h0, 0, 0, 8'h00, 2'b00, "idle");
  endtask

  task automatic rd(input logic [3:0] a, input string tag);
    cyc(a, 1, 0, 8'h00, 2'b00, tag);
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d, input string tag);
    cyc(a, 0, 1, d, 2'b00, tag);
  endtask

  function automatic logic [7:0] status_now();
    return bus_rdata;
  endfunction

  initial begin
    #2_000_000;
    n_run++; n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    m_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    rd(4'h0, "R1 reset status");
    chk("R1 reset status literal", {8'h00, status_now()}, 16'h0000);
    // R2 freeze bit writable, flags not
    wr(4'h0, 8'hFF, "R2 write");
    rd(4'h0, "R2 readback");
    chk("R2 only freeze bit", {8'h00, status_now()}, 16'h0004);
    wr(4'h0, 8'h00, "R2 clear");
    // R3 reload and divide-by-4
    wr(4'h3, 8'h00, "R3 reload");
    rd(4'h2, "R3 high");
    chk("R3 reload high", {8'h00, status_now()}, 16'h00FF);
    rd(4'h3, "R3 low");
    chk("R3 reload low", {8'h00, status_now()}, 16'h00FC);
    rd(4'h3, "R3 low");
    rd(4'h3, "R3 step after four");
    // R4 wrap flag set
    idle(20);
    rd(4'h0, "R4 wrap set");
    chk("R4 wrap bit", {15'd0, status_now()[5]}, 16'd1);
    // R9 alias access keeps flag
    rd(4'h5, "R9 alias read");
    wr(4'h5, 8'h12, "R9 alias write");
    rd(4'h4, "R9 alias high");
    chk("R9 flag kept", {15'd0, i_cc_timer_flags.bus_rdata[0]}, {15'd0, m_read(4'h4)[0]});
    rd(4'h0, "R9 status after alias");
    chk("R9 wrap kept", {15'd0, status_now()[5]}, 16'd1);
    rd(4'h3, "R8 armed clear");
    rd(4'h0, "R8 cleared");
    chk("R8 wrap cleared", {15'd0, status_now()[5]}, 16'd0);
    // R8 unarmed access does not clear
    wr(4'h3, 8'h00, "R8 reload");
    idle(18);
    rd(4'h3, "R8 unarmed access");
    rd(4'h0, "R8 still set");
    chk("R8 unarmed kept", {15'd0, status_now()[5]}, 16'd1);
    // R5/R10 compare hit after arming read survives clear of wrap
    wr(4'h3, 8'h00, "R5 reload");
    wr(4'hA, 8'hFF, "R5 cmp high");
    wr(4'hB, 8'hFE, "R5 cmp low");
    rd(4'h0, "R10 arm wrap");
    idle(6);
    rd(4'h3, "R10 clear wrap");
    rd(4'h0, "R10 status");
    chk("R10 late compare kept", {14'd0, status_now()[6], status_now()[5]}, 16'b10);
    // R6 capture on both pins
    cyc(4'h0, 0, 0, 8'h00, 2'b11, "R6 pins up");
    cyc(4'h0, 0, 0, 8'h00, 2'b11, "R6 hold");
    cyc(4'h0, 0, 0, 8'h00, 2'b11, "R6 hold");
    cyc(4'h0, 1, 0, 8'h00, 2'b11, "R6 status");
    chk("R6 capture flags", {14'd0, status_now()[7], status_now()[4]}, 16'b11);
    rd(4'h7, "R6 capture A low");
    rd(4'h9, "R6 capture B low");
    // R7 PWM mode
    wr(4'h1, 8'h01, "R7 mode");
    rd(4'h0, "R7 arm");
    rd(4'h7, "R7 clear capA");
    wr(4'h3, 8'h00, "R7 reload");
    wr(4'hC, 8'hFF, "R7 cmpB high");
    wr(4'hD, 8'hFE, "R7 cmpB low");
    idle(8);
    rd(4'h0, "R7 status");
    chk("R7 capA via compare B", {15'd0, status_now()[7]}, 16'd1);
    wr(4'h1, 8'h00, "R7 mode off");
    // R11 freeze
    wr(4'h0, 8'h04, "R11 freeze");
    rd(4'h3, "R11 count");
    idle(9);
    rd(4'h3, "R11 count held");
    wr(4'h3, 8'h00, "R11 reload while frozen");
    rd(4'h3, "R11 reload seen");
    chk("R11 reload frozen", {8'h00, status_now()}, 16'h00FC);
    idle(9);
    rd(4'h3, "R11 still held");
    wr(4'h0, 8'h00, "R11 unfreeze");
    // random phase
    void'($urandom(32'd4242));
    for (int i = 0; i < 4000; i++) begin
      logic [3:0] a;
      int op;
      string tg;
      a = 4'($urandom % 16);
      op = int'($urandom % 10);
      tg = (a == 0) ? "R1 random status" :
           (a <= 5) ? "R3 random counter" :
           (a <= 9) ? "R6 random capture" : "R5 random compare";
      if (op < 4) cyc(a, 1, 0, 8'h00, 2'($urandom), tg);
      else if (op == 4 && (a != 4'h0 || ($urandom % 4) == 0))
        cyc(a, 0, 1, 8'($urandom), 2'($urandom), tg);
      else cyc(4'h0, 0, 0, 8'h00, 2'($urandom), tg);
    end
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule